// File: doc/BRIEF.md
# I2C Fault Monitor

This block sits beside an I2C transfer engine and watches the already synchronized SCL and SDA lines for two kinds of fault. The first is a protocol fault: a START or STOP condition that appears while an address bit, a data bit or an acknowledge bit is being moved. The second is a stall: SCL held low for as many system clocks as a programmable timeout value. Both kinds are reported only while the transfer engine says the controller is taking part in the transfer, either as master or as addressed slave.

On the first fault the block emits a one-cycle fault pulse and loads a status code. It then raises both an interrupt and a request to let go of the SCL and SDA lines. All of these stay latched until the asynchronous reset is applied. Later faults do not overwrite the stored code. Reading the status output has no side effect.

Top module: `i2c_fault_monitor`

## Requirements
- R1: While reset is asserted and after its release, with no fault yet seen, `irq`, `release_lines` and `err_pulse` are 0 and `err_code` is 8'hF8 (no fault).
- R2: A START (SDA sampled 1 then 0 on two consecutive clocks while SCL is sampled 1 on both) seen while `engaged` and `in_frame` are both 1 latches a fault. One clock later, `err_pulse`, `irq` and `release_lines` are 1 and `err_code` is 8'h00.
- R3: A STOP (SDA sampled 0 then 1 while SCL is sampled 1 on both clocks) under the same conditions gives the same result as R2, with code 8'h00.
- R4: A START or STOP seen while `in_frame` is 0 causes no fault.
- R5: No fault of either kind is raised while `engaged` is 0.
- R6: While `engaged` is 1 and `timeout_limit` is N > 0, SCL sampled low on N consecutive clocks latches a fault. One clock after the Nth low sample, `err_pulse`, `irq` and `release_lines` are 1 and `err_code` is 8'h90.
- R7: The low-time count restarts from zero whenever SCL is sampled high or `engaged` is 0.
- R8: A `timeout_limit` of 0 turns the stall check off.
- R9: Once a fault is latched, `irq`, `release_lines` and `err_code` hold until reset. `err_pulse` lasts exactly one clock. A later fault neither pulses again nor changes the code.
- R10: SDA changes while SCL is sampled low are not START or STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_sync | input | 1 | Synchronized SCL level |
| sda_sync | input | 1 | Synchronized SDA level |
| in_frame | input | 1 | High while an address, data or acknowledge bit is in progress |
| engaged | input | 1 | High while the controller is master or addressed slave |
| timeout_limit | input | TW (16) | Stall limit in system clocks; 0 turns the check off |
| err_pulse | output | 1 | One-clock pulse when a fault is first latched |
| err_code | output | 8 | Status code: F8 none, 00 misplaced START/STOP, 90 SCL stall |
| release_lines | output | 1 | Request to release SCL and SDA |
| irq | output | 1 | Interrupt, held until reset |

## Verification
The embedded assertions check on every cycle the properties that need no scenario. The fault pulse never lasts two cycles and always comes with the interrupt. A latched fault keeps its flag and code. The low-time count drops to zero after SCL is seen high and never passes the limit. An unengaged cycle never yields a pulse, and a qualified START or STOP is followed by code 00. Only the bench's scenarios can show that the stall fires on exactly the Nth low sample and not one clock sooner. They also show that SCL highs and disengagement restart the count, that a zero limit disables the check, and that out-of-frame, unengaged and SCL-low SDA edges pass without a fault.

// File: rtl/i2c_fault_pkg.sv
package i2c_fault_pkg;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_IDLE  = 8'hF8;
  localparam logic [CODE_W-1:0] CODE_FRAME = 8'h00;
  localparam logic [CODE_W-1:0] CODE_STALL = 8'h90;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_FRAME = 2'd1,
    FK_STALL = 2'd2
  } fault_kind_e;

  function automatic logic [CODE_W-1:0] kind_to_code(fault_kind_e k);
    case (k)
      FK_FRAME: kind_to_code = CODE_FRAME;
      FK_STALL: kind_to_code = CODE_STALL;
      default:  kind_to_code = CODE_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_i;
    sda_d = sda_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  // Both SCL samples must be high around the SDA edge (R10)
  always_comb begin
    start_o = scl_q & scl_i & sda_q & ~sda_i;
    stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  end

  assert_scl_low_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_i |-> !(start_o || stop_o));
endmodule

// File: rtl/i2c_lowclk_timer.sv
module i2c_lowclk_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          active_i,
  input  logic [TW-1:0] limit_i,
  output logic          stall_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          armed;

  always_comb begin
    armed   = (limit_i != '0);
    cnt_en  = active_i & ~scl_i & armed & (cnt_q < limit_i);
    cnt_d   = cnt_q;
    if (scl_i || !active_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + ONE;
    end
    stall_o = active_i & ~scl_i & armed & (cnt_q == limit_i - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i || !active_i) |=> (cnt_q == '0));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q <= limit_i) && !scl_i) |=> (cnt_q <= $past(limit_i)));
endmodule

// File: rtl/i2c_fault_latch.sv
module i2c_fault_latch
  import i2c_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_hit_i,
  input  logic              stall_hit_i,
  output logic              pulse_o,
  output logic              latched_o,
  output logic [CODE_W-1:0] code_o
);
  fault_kind_e kind_q, kind_d;
  logic        pulse_q, pulse_d;
  logic        new_fault;

  always_comb begin
    new_fault = (kind_q == FK_NONE) & (frame_hit_i | stall_hit_i);
    kind_d    = kind_q;
    pulse_d   = 1'b0;
    if (new_fault) begin
      pulse_d = 1'b1;
      kind_d  = frame_hit_i ? FK_FRAME : FK_STALL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= FK_NONE;
      pulse_q <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    pulse_o   = pulse_q;
    latched_o = (kind_q != FK_NONE);
    code_o    = kind_to_code(kind_q);
  end

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  assert_pulse_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> latched_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latched_o |=> (latched_o && $stable(code_o)));
endmodule

// File: rtl/i2c_fault_monitor.sv
module i2c_fault_monitor
  import i2c_fault_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_sync,
  input  logic              sda_sync,
  input  logic              in_frame,
  input  logic              engaged,
  input  logic [TW-1:0]     timeout_limit,
  output logic              err_pulse,
  output logic [CODE_W-1:0] err_code,
  output logic              release_lines,
  output logic              irq
);
  logic start_hit, stop_hit;
  logic frame_hit, stall_hit;
  logic latched;

  i2c_cond_detect u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_sync),
    .sda_i   (sda_sync),
    .start_o (start_hit),
    .stop_o  (stop_hit)
  );

  i2c_lowclk_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_sync),
    .active_i (engaged),
    .limit_i  (timeout_limit),
    .stall_o  (stall_hit)
  );

  // Misplaced conditions count only inside a frame and while engaged (R2..R5)
  always_comb begin
    frame_hit = engaged & in_frame & (start_hit | stop_hit);
  end

  i2c_fault_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_hit_i (frame_hit),
    .stall_hit_i (stall_hit),
    .pulse_o     (err_pulse),
    .latched_o   (latched),
    .code_o      (err_code)
  );

  always_comb begin
    irq           = latched;
    release_lines = latched;
  end

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !engaged |=> !err_pulse);

  assert_frame_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_hit && !irq) |=> (err_code == CODE_FRAME));
endmodule

// File: tb/i2c_fault_monitor_tb_top.sv
module i2c_fault_monitor_tb_top;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl_sync = 1'b1, sda_sync = 1'b1;
  logic          in_frame = 1'b0, engaged = 1'b0;
  logic [TW-1:0] timeout_limit = '0;
  logic          err_pulse, release_lines, irq;
  logic [7:0]    err_code;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_fault_monitor #(.TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .sda_sync(sda_sync),
    .in_frame(in_frame), .engaged(engaged), .timeout_limit(timeout_limit),
    .err_pulse(err_pulse), .err_code(err_code),
    .release_lines(release_lines), .irq(irq)
  );

  // {rst, eng, frm, scl, sda, pulse, irq, code[7:0]}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {5'b11111, 2'b00, 8'hF8},  // R1 reset, idle bus
    {5'b01010, 2'b00, 8'hF8},  // R4 START outside frame
    {5'b01100, 2'b00, 8'hF8},  // R10 SCL low
    {5'b01101, 2'b00, 8'hF8},  // R10 SDA rises under SCL low
    {5'b01111, 2'b00, 8'hF8},  // SCL high again
    {5'b01110, 2'b11, 8'h00},  // R2 START inside frame
    {5'b01111, 2'b01, 8'h00},  // R9 STOP after latch: no pulse, code kept
    {5'b10111, 2'b00, 8'hF8},  // R1 reset, not engaged
    {5'b00110, 2'b00, 8'hF8},  // R5 START unengaged
    {5'b00111, 2'b00, 8'hF8},  // R5 STOP unengaged
    {5'b01110, 2'b11, 8'h00},  // R2 START once engaged
    {5'b11111, 2'b00, 8'hF8},  // R1 reset
    {5'b01010, 2'b00, 8'hF8},  // R4 START outside frame
    {5'b01111, 2'b11, 8'h00}   // R3 STOP inside frame
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic p, input logic q, input logic [7:0] c);
    chk(req, {31'd0, err_pulse}, {31'd0, p});
    chk(req, {31'd0, irq}, {31'd0, q});
    chk(req, {31'd0, release_lines}, {31'd0, q});
    chk(req, {24'd0, err_code}, {24'd0, c});
  endtask

  task automatic do_reset(input logic [TW-1:0] lim, input logic eng);
    @(negedge clk);
    rst_n = 1'b0;
    scl_sync = 1'b1; sda_sync = 1'b1; in_frame = 1'b1; engaged = eng;
    timeout_limit = lim;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic low_cycles(input int n);
    scl_sync = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: state during reset
    timeout_limit = 16'd5;
    repeat (2) @(negedge clk);
    chk_out("R1 in reset", 1'b0, 1'b0, 8'hF8);

    // Vector table, limit 5
    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      if (v[14]) begin
        do_reset(16'd5, v[13]);
      end else begin
        @(negedge clk);
      end
      engaged = v[13]; in_frame = v[12]; scl_sync = v[11]; sda_sync = v[10];
      @(negedge clk);
      chk_out($sformatf("R%0s vec%0d", "x", i), v[9], v[8], v[7:0]);
    end

    // R6: stall fires on exactly the 4th low sample
    do_reset(16'd4, 1'b1);
    low_cycles(3);
    chk_out("R6 before limit", 1'b0, 1'b0, 8'hF8);
    @(negedge clk);
    chk_out("R6 at limit", 1'b1, 1'b1, 8'h90);
    @(negedge clk);
    chk_out("R9 pulse ends", 1'b0, 1'b1, 8'h90);
    // R9: later START in frame keeps stall code
    scl_sync = 1'b1;
    @(negedge clk);
    sda_sync = 1'b0;
    @(negedge clk);
    chk_out("R9 code kept", 1'b0, 1'b1, 8'h90);

    // R7: SCL high restarts the count
    do_reset(16'd4, 1'b1);
    low_cycles(3);
    scl_sync = 1'b1;
    @(negedge clk);
    low_cycles(3);
    chk_out("R7 reload on SCL high", 1'b0, 1'b0, 8'hF8);
    scl_sync = 1'b1;
    @(negedge clk);

    // R8: zero limit disables stall check
    do_reset(16'd0, 1'b1);
    low_cycles(20);
    chk_out("R8 zero limit", 1'b0, 1'b0, 8'hF8);
    scl_sync = 1'b1;

    // R5/R7: unengaged low time is not counted
    do_reset(16'd4, 1'b0);
    low_cycles(10);
    chk_out("R5 stall unengaged", 1'b0, 1'b0, 8'hF8);
    engaged = 1'b1;
    repeat (3) @(negedge clk);
    chk_out("R7 restart after engage", 1'b0, 1'b0, 8'hF8);
    @(negedge clk);
    chk_out("R6 stall after engage", 1'b1, 1'b1, 8'h90);

    // R1: reset clears a latched fault
    do_reset(16'd4, 1'b1);
    @(negedge clk);
    chk_out("R1 reset clears", 1'b0, 1'b0, 8'hF8);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule